// File: doc/BRIEF.md
# Daisy-Chain Serial Configuration Receiver

This block is the loading front end of a programmable device that leads a configuration chain. It drives a configuration clock to an external serial memory, which moves to its next bit on each rising edge of that clock. On the following rising edge the block samples the memory's data pin. It searches the incoming stream for a start pattern and then reads a 24-bit length count. It takes the next `OWN_BITS` bits for its own store and re-emits everything else on a serial output, so that the next device in the chain can load from the same memory. The bits it re-emits are the leading filler, the start pattern, the length count and every bit after its own share.

The configuration clock runs at half the system clock rate, so each of its edges falls on a system clock edge. A forwarded bit leaves on a falling configuration-clock edge, one and a half clock periods after it was sampled, so the downstream device can take it on its next rising edge. When the counted bits reach the length count, the clock runs two more rising edges to drain the forward path, stops low, and raises the done flag. At the same moment the busy output, which is low during loading and can gate the memory's chip enable, goes high. An active-low reset aborts loading and holds the memory's address pointer in reset.

Top module: `cfg_serial_rx`

## Requirements
- R1: While loading, `cclk_o` is high for one system cycle and low for the next. It rises exactly T+2 times per load, where T is the number of stream bits consumed (filler plus length count). After done it stays low.
- R2: `din_i` is sampled at the system clock edge on which `cclk_o` rises. The memory holds bit 0 during reset, so the first rising edge after reset takes bit 0.
- R3: Before the start pattern is found, received bits are not counted. The start pattern is 4'b0010 with its MSB received first. Leading filler bits (ones) before it are skipped without being counted.
- R4: The 24 bits after the start pattern are the length count, MSB first. It gives the total number of bits counted from the first start-pattern bit, header included. A count of 28 or less ends loading right after the header.
- R5: The first `OWN_BITS` bits after the header are delivered through `own_we_o`, `own_idx_o` = 0,1,2,... in order, and `own_bit_o`. These bits are not forwarded: `dout_o` shows 1 in their slots.
- R6: Filler, start pattern, length count and all bits after the own bits are forwarded. A bit sampled on rising edge k is seen by the downstream device on rising edge k+2. On rising edges 0 and 1 it sees 1.
- R7: `dout_o` changes only on a system edge where `cclk_o` falls, three system cycles after the sampling edge.
- R8: After the last counted bit, two more rising edges occur. On the following falling edge `done_o` and `cfg_busy_no` go high together and `dout_o` is held at 1. `cfg_busy_no` is low during loading.
- R9: If the length count ends inside the own-bit region, loading stops there and no further own writes occur.
- R10: `rst_ni` low aborts loading at once. Then `cclk_o`=0, `done_o`=0, `dout_o`=1, and `mem_rst_no`=0 until the first clock edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, aborts loading |
| din_i | input | 1 | Serial data from external memory |
| cclk_o | output | 1 | Configuration clock to memory and chain |
| mem_rst_no | output | 1 | Active-low reset of memory address pointer |
| dout_o | output | 1 | Forwarded serial data to next chained device |
| cfg_busy_no | output | 1 | Low while loading, high once done |
| done_o | output | 1 | Loading complete |
| own_we_o | output | 1 | Strobe: own configuration bit valid this cycle |
| own_idx_o | output | IDX_W | Index of own configuration bit |
| own_bit_o | output | 1 | Own configuration bit value |

## Verification
A downstream model samples `dout_o` on every rising edge of `cclk_o`. A queue fed by the stream builder checks each value, so a forward path one stage short or long shifts the whole chain image and is caught at once. Streams with filler, an exact own-length count, a count that truncates the own region, and a header-only count cover the paths where a state machine could miss the start pattern, forward own bits, or keep writing past the count. A mid-load reset checks that the clock stops and the memory pointer is reset. Another check looks for any `dout_o` change on a system edge that is not a falling configuration-clock edge; a design that updates the output on the rising edge would fail it.

// File: rtl/cfg_rx_pkg.sv
package cfg_rx_pkg;
  typedef enum logic [2:0] {
    ST_SYNC, ST_LEN, ST_OWN, ST_FWD, ST_DRAIN, ST_DONE
  } rx_state_e;
endpackage

// File: rtl/cfg_clk_gen.sv
module cfg_clk_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic cclk_o,
  output logic rise_o,
  output logic fall_o
);
  logic ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= 1'b0;
    else         ph_q <= ph_q ? 1'b0 : run_i;
  end

  assign cclk_o = ph_q;
  assign rise_o = ~ph_q & run_i;  // cclk rises at the end of this cycle
  assign fall_o = ph_q;

  a_r1_stop_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !cclk_o);
  a_r1_high_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cclk_o |=> !cclk_o);
endmodule

// File: rtl/cfg_frame_ctl.sv
module cfg_frame_ctl
  import cfg_rx_pkg::*;
#(
  parameter int          PRE_W    = 4,
  parameter logic [3:0]  PRE_VAL  = 4'b0010,
  parameter int          LEN_W    = 24,
  parameter int          OWN_BITS = 16,
  parameter int          DRAIN_N  = 2,
  localparam int         IDX_W    = (OWN_BITS > 1) ? $clog2(OWN_BITS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             bit_i,
  output logic             run_o,
  output logic             done_o,
  output logic             fwd_o,
  output logic             own_we_o,
  output logic [IDX_W-1:0] own_idx_o,
  output logic             own_bit_o
);
  localparam int HDR = PRE_W + LEN_W;
  localparam int DW  = $clog2(DRAIN_N + 1);

  rx_state_e        st_q;
  logic [PRE_W-1:0] sh_q, sh_nx;
  logic [LEN_W-1:0] cnt_q, len_q, cnt_nx, len_nx;
  logic [IDX_W-1:0] idx_q;
  logic [DW-1:0]    drn_q;

  assign sh_nx  = {sh_q[PRE_W-2:0], bit_i};
  assign len_nx = {len_q[LEN_W-2:0], bit_i};
  assign cnt_nx = cnt_q + 1'b1;

  always_comb begin
    unique case (st_q)
      ST_SYNC, ST_LEN, ST_FWD: fwd_o = 1'b1;
      default:                 fwd_o = 1'b0;
    endcase
  end

  assign run_o     = (st_q != ST_DONE);
  assign done_o    = (st_q == ST_DONE);
  assign own_we_o  = rise_i && (st_q == ST_OWN);
  assign own_idx_o = idx_q;
  assign own_bit_o = bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_SYNC;
      sh_q  <= '1;
      cnt_q <= '0;
      len_q <= '0;
      idx_q <= '0;
      drn_q <= '0;
    end else begin
      unique case (st_q)
        ST_SYNC: if (rise_i) begin
          sh_q <= sh_nx;
          if (sh_nx == PRE_VAL[PRE_W-1:0]) begin
            cnt_q <= LEN_W'(PRE_W);
            st_q  <= ST_LEN;
          end
        end
        ST_LEN: if (rise_i) begin
          len_q <= len_nx;
          cnt_q <= cnt_nx;
          if (cnt_nx == LEN_W'(HDR))
            st_q <= (len_nx <= LEN_W'(HDR)) ? ST_DRAIN : ST_OWN;
        end
        ST_OWN: if (rise_i) begin
          cnt_q <= cnt_nx;
          idx_q <= idx_q + 1'b1;
          if (cnt_nx == len_q)                        st_q <= ST_DRAIN;
          else if (idx_q == IDX_W'(OWN_BITS - 1))     st_q <= ST_FWD;
        end
        ST_FWD: if (rise_i) begin
          cnt_q <= cnt_nx;
          if (cnt_nx == len_q) st_q <= ST_DRAIN;
        end
        ST_DRAIN: begin
          if (rise_i) drn_q <= drn_q + 1'b1;
          if (fall_i && drn_q == DW'(DRAIN_N)) st_q <= ST_DONE;
        end
        default: ;
      endcase
    end
  end

  a_r5_own_idx_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    own_we_o |-> (own_idx_o <= IDX_W'(OWN_BITS - 1)));
  a_r8_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);
  a_r3_sync_uncounted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SYNC) |-> (cnt_q == '0));
  a_r9_no_write_after_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    own_we_o |-> (cnt_q < len_q));
endmodule

// File: rtl/cfg_fwd_pipe.sv
module cfg_fwd_pipe #(
  parameter logic IDLE = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  input  logic fall_i,
  input  logic bit_i,
  input  logic fwd_i,
  input  logic done_i,
  output logic dout_o
);
  logic s1_q, s2_q, dout_q;

  // two rise stages then a fall stage: 1.5 cclk periods
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= IDLE;
      s2_q   <= IDLE;
      dout_q <= IDLE;
    end else begin
      if (rise_i) begin
        s1_q <= fwd_i ? bit_i : IDLE;
        s2_q <= s1_q;
      end
      if (fall_i) dout_q <= s2_q;
    end
  end

  assign dout_o = dout_q;

  a_r7_dout_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dout_q) |-> $past(fall_i));
  a_r8_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (dout_q == IDLE));
endmodule

// File: rtl/cfg_serial_rx.sv
module cfg_serial_rx #(
  parameter int  LEN_W    = 24,
  parameter int  OWN_BITS = 16,
  localparam int IDX_W    = (OWN_BITS > 1) ? $clog2(OWN_BITS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             din_i,
  output logic             cclk_o,
  output logic             mem_rst_no,
  output logic             dout_o,
  output logic             cfg_busy_no,
  output logic             done_o,
  output logic             own_we_o,
  output logic [IDX_W-1:0] own_idx_o,
  output logic             own_bit_o
);
  logic run, rise, fall, fwd, done, mem_rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mem_rst_q <= 1'b0;
    else         mem_rst_q <= 1'b1;
  end

  cfg_clk_gen u_clk (
    .clk_i, .rst_ni, .run_i(run), .cclk_o, .rise_o(rise), .fall_o(fall)
  );

  cfg_frame_ctl #(
    .PRE_W(4), .PRE_VAL(4'b0010), .LEN_W(LEN_W), .OWN_BITS(OWN_BITS), .DRAIN_N(2)
  ) u_ctl (
    .clk_i, .rst_ni, .rise_i(rise), .fall_i(fall), .bit_i(din_i),
    .run_o(run), .done_o(done), .fwd_o(fwd),
    .own_we_o, .own_idx_o, .own_bit_o
  );

  cfg_fwd_pipe #(.IDLE(1'b1)) u_fwd (
    .clk_i, .rst_ni, .rise_i(rise), .fall_i(fall), .bit_i(din_i),
    .fwd_i(fwd), .done_i(done), .dout_o
  );

  assign mem_rst_no  = mem_rst_q;
  assign done_o      = done;
  assign cfg_busy_no = done;

  a_r10_no_rise_in_mem_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_rst_q |-> !cclk_o);
endmodule

// File: tb/cfg_serial_rx_tb_top.sv
module cfg_serial_rx_tb_top;
  localparam int OWN_BITS = 16;
  localparam int IDX_W    = $clog2(OWN_BITS);
  localparam int HDR      = 28;

  logic clk_i = 1'b0, rst_ni = 1'b0, din_i = 1'b1;
  logic cclk_o, mem_rst_no, dout_o, cfg_busy_no, done_o, own_we_o, own_bit_o;
  logic [IDX_W-1:0] own_idx_o;

  always #5 clk_i = ~clk_i;

  cfg_serial_rx #(.LEN_W(24), .OWN_BITS(OWN_BITS)) dut_i (.*);

  int errors = 0, checks = 0, cycles = 0, rises = 0;
  bit mem_q[$];
  bit exp_q[$];
  int own_q[$];   // {idx, bit} packed as idx*2+bit
  int addr = 0;
  bit mon_en = 0;
  logic prev_cclk = 1'b0, prev_dout = 1'b1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // memory model: advances on cclk rise, held at 0 in reset
  always @(posedge clk_i) begin
    #1;
    if (!mem_rst_no) addr = 0;
    else if (cclk_o && !prev_cclk) addr++;
    din_i = (addr < mem_q.size()) ? mem_q[addr] : 1'b1;
  end

  // monitor: downstream device and own-bit scoreboard
  always @(posedge clk_i) begin
    #2;
    if (rst_ni && mon_en) begin
      if (cclk_o && !prev_cclk) begin
        rises++;
        if (exp_q.size() == 0) chk(0, "R6 extra downstream rise", 1, 0);
        else begin
          automatic bit e = exp_q.pop_front();
          chk(dout_o == e, "R6 downstream bit", int'(dout_o), int'(e));
        end
      end
      if (dout_o != prev_dout)
        chk(!cclk_o && prev_cclk, "R7 dout change off falling edge", int'(cclk_o), 0);
      if (own_we_o) begin
        if (own_q.size() == 0) chk(0, "R9 extra own write", int'(own_idx_o), -1);
        else begin
          automatic int e = own_q.pop_front();
          chk(int'(own_idx_o) * 2 + int'(own_bit_o) == e, "R5 own idx/bit",
              int'(own_idx_o) * 2 + int'(own_bit_o), e);
        end
      end
    end
    prev_cclk = cclk_o;
    prev_dout = dout_o;
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic build(input int filler, input int len_v, input int seed);
    int s = seed;
    mem_q.delete(); exp_q.delete(); own_q.delete();
    exp_q.push_back(1'b1); exp_q.push_back(1'b1);
    for (int i = 0; i < filler; i++) begin mem_q.push_back(1'b1); exp_q.push_back(1'b1); end
    for (int i = 3; i >= 0; i--) begin
      mem_q.push_back(4'b0010 >> i); exp_q.push_back(4'b0010 >> i);
    end
    for (int i = 23; i >= 0; i--) begin
      mem_q.push_back(len_v >> i); exp_q.push_back(len_v >> i);
    end
    for (int p = 0; p < len_v - HDR; p++) begin
      automatic bit b;
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
      b = s[3];
      mem_q.push_back(b);
      if (p < OWN_BITS) begin exp_q.push_back(1'b1); own_q.push_back(p * 2 + int'(b)); end
      else exp_q.push_back(b);
    end
  endtask

  task automatic do_reset();
    mon_en = 0;
    @(negedge clk_i); rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(cclk_o == 1'b0, "R10 cclk in reset", int'(cclk_o), 0);
    chk(mem_rst_no == 1'b0, "R10 mem reset active", int'(mem_rst_no), 0);
    chk(done_o == 1'b0 && cfg_busy_no == 1'b0, "R10 done/busy in reset", int'(done_o), 0);
    chk(dout_o == 1'b1, "R10 dout idle in reset", int'(dout_o), 1);
    rises = 0; prev_cclk = 1'b0; prev_dout = 1'b1;
    mon_en = 1; rst_ni = 1'b1;
    @(negedge clk_i);
    chk(mem_rst_no == 1'b1, "R10 mem reset released", int'(mem_rst_no), 1);
  endtask

  task automatic run_case(input string tag, input int filler, input int len_v, input int seed);
    int t_bits = filler + len_v;
    build(filler, len_v, seed);
    do_reset();
    chk(cfg_busy_no == 1'b0, "R8 busy low while loading", int'(cfg_busy_no), 0);
    for (int i = 0; i < 4 * t_bits + 40 && !done_o; i++) @(negedge clk_i);
    chk(done_o == 1'b1, "R8 done reached", int'(done_o), 1);
    chk(cfg_busy_no == 1'b1, "R8 busy high at done", int'(cfg_busy_no), 1);
    chk(cclk_o == 1'b0, "R1 cclk low at done", int'(cclk_o), 0);
    repeat (10) @(negedge clk_i);
    chk(rises == t_bits + 2, "R1 rise count", rises, t_bits + 2);
    chk(dout_o == 1'b1, "R8 dout held high", int'(dout_o), 1);
    chk(exp_q.size() == 0, "R6 forwarded stream complete", exp_q.size(), 0);
    chk(own_q.size() == 0, "R5 own bits complete", own_q.size(), 0);
    $display("case %s done", tag);
  endtask

  initial begin
    run_case("R3 filler+overflow", 3, HDR + OWN_BITS + 5, 32'h1234_5671);
    run_case("R5 exact own", 0, HDR + OWN_BITS, 32'h0bad_f00d);
    run_case("R9 truncated own", 2, HDR + 10, 32'h7777_1111);
    run_case("R4 header only", 1, HDR, 32'h2468_ace1);
    // R10: abort mid-load
    build(0, HDR + OWN_BITS + 8, 32'h5a5a_0101);
    do_reset();
    repeat (60) @(posedge clk_i);
    #3 rst_ni = 1'b0; mon_en = 0;
    #1;
    chk(cclk_o == 1'b0 && mem_rst_no == 1'b0, "R10 abort stops clock", int'(cclk_o), 0);
    chk(done_o == 1'b0 && dout_o == 1'b1, "R10 abort state", int'(dout_o), 1);
    run_case("R2 after abort", 4, HDR + OWN_BITS + 12, 32'h0f0f_3c3c);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule